// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line-Fault and Wake Detect

This block turns an asynchronous serial line into characters. It samples the line on a 16x oversampling tick and looks for a start bit. It then shifts in seven or eight data bits, plus an optional parity bit, and checks the stop bit. Each character that ends with a good stop bit goes into a small first-in, first-out queue, together with the parity bit that arrived with it. The host sees the oldest queued character and its parity bit, a flag that says data is waiting, and a single status bit. It pops the oldest entry with a one-cycle read strobe.

The status bit has two meanings. In normal operation it reports a line fault: the stop bit was sampled low. The faulty character is discarded, and the flag stays set until a later character ends correctly or a configuration write clears it. A read does not clear it. While the block is held in sleep, reception stops, the queue is emptied, and the same bit instead reports any change of level on the line. This lets the host learn that a remote sender has woken up.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `data_avail`, `fault_wake`, `head_par` and `head_data` are all 0.
- R2: A start bit is accepted only if the line is still low 8 ticks after the first tick that saw it low. Each later bit is sampled 16 ticks after the previous one. In 8-bit mode the character arrives LSB first into `head_data[7:0]`.
- R3: With `cfg_seven` = 1, seven data bits are received and `head_data[7]` reads 0.
- R4: With `cfg_par_en` = 1, one further bit is sampled after the data bits and kept as `head_par` of that entry. With `cfg_par_en` = 0, no parity bit is expected and the stored `head_par` is 0.
- R5: The queue holds 8 entries and returns them oldest first. A character that completes while the queue is full is dropped.
- R6: `data_avail` is 1 while the queue is non-empty. A `rd_pop` pulse removes the oldest entry. While `data_avail` is 0, `head_data` and `head_par` are 0.
- R7: A 0 sampled at the first stop-bit position sets `fault_wake`. That character is not queued, and the receiver resumes its search for a start bit, so the next clean character is received intact. Only one stop bit is ever checked.
- R8: `fault_wake` is cleared outside sleep by a correctly ended character or by a `cfg_wr` pulse, but never by `rd_pop`. If a character ends in the same cycle as `cfg_wr`, the character's result wins.
- R9: A low pulse on the line shorter than 8 ticks is not taken as a start bit. Nothing is queued and no fault is flagged.
- R10: Raising `sleep` empties the queue and clears `fault_wake`. No character is received while `sleep` is 1. Lowering `sleep` clears `fault_wake` again.
- R11: While `sleep` stays 1, any change of level on `rx_line` sets `fault_wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line; idles high; asynchronous to `clk` |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_seven | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | 1 means a parity bit follows the data bits |
| cfg_wr | input | 1 | One-cycle configuration-write pulse; clears the fault flag |
| rd_pop | input | 1 | One-cycle pulse; removes the oldest queue entry |
| sleep | input | 1 | Sleep status; suspends reception and enables wake detection |
| head_data | output | 8 | Oldest queued character, or 0 when empty |
| head_par | output | 1 | Parity bit stored with the oldest character |
| data_avail | output | 1 | Queue holds at least one unread character |
| fault_wake | output | 1 | Stop-bit fault outside sleep, line activity in sleep |

## Verification
The properties take the host side as well behaved. `rd_pop` and `cfg_wr` are single-cycle pulses. `cfg_seven` and `cfg_par_en` change only while the line is idle. `sleep` is raised or lowered only while the line is high and no character is in flight. The stimulus keeps to these rules: it changes configuration only between whole frames, drives the line at clock-low instants with bit periods of exactly 16 ticks, and holds the line high whenever `sleep` changes. Fault frames keep the stop position low for less than one bit and then return high, so the restarted hunt sees a false start and not a new character.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int SRX_DW = 8;
  localparam int SRX_EW = SRX_DW + 1;

  typedef enum logic [1:0] {
    RX_HUNT,
    RX_START,
    RX_SHIFT,
    RX_STOP
  } rx_state_e;

  // number of bits shifted in between start and stop
  function automatic logic [3:0] srx_frame_bits(input logic seven, input logic par_en);
    return 4'd8 - {3'd0, seven} + {3'd0, par_en};
  endfunction

  // right-justify the shift register and split into {parity, data}
  function automatic logic [SRX_EW-1:0] srx_align(input logic [SRX_EW-1:0] sh,
                                                  input logic seven,
                                                  input logic par_en);
    logic [3:0]        n;
    logic [SRX_EW-1:0] v;
    logic [SRX_EW-1:0] res;
    n   = srx_frame_bits(seven, par_en);
    v   = sh >> (4'd9 - n);
    res = '0;
    res[7:0] = seven ? {1'b0, v[6:0]} : v[7:0];
    res[8]   = par_en ? v[n - 4'd1] : 1'b0;
    return res;
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_deframer.sv
module srx_deframer
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_s,
  input  logic              tick,
  input  logic              seven,
  input  logic              par_en,
  input  logic              hold,
  output logic              frame_done,
  output logic              stop_ok,
  output logic [SRX_EW-1:0] frame_word
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] MID  = CW'(OVERSAMPLE / 2 - 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [3:0]        bitn;
  logic [SRX_EW-1:0] sh;
  logic [3:0]        nbits;

  assign nbits      = srx_frame_bits(seven, par_en);
  assign frame_done = (state == RX_STOP) && tick && (cnt == LAST) && !hold;
  assign stop_ok    = rx_s;
  assign frame_word = srx_align(sh, seven, par_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_HUNT;
      cnt   <= '0;
      bitn  <= '0;
      sh    <= '0;
    end else if (hold) begin
      state <= RX_HUNT;
      cnt   <= '0;
    end else if (tick) begin
      case (state)
        RX_HUNT: begin
          if (!rx_s) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end
        RX_START: begin
          if (cnt == MID) begin
            state <= rx_s ? RX_HUNT : RX_SHIFT;
            cnt   <= '0;
            bitn  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_SHIFT: begin
          if (cnt == LAST) begin
            sh  <= {rx_s, sh[SRX_EW-1:1]};
            cnt <= '0;
            if (bitn == nbits - 4'd1) state <= RX_STOP;
            else                      bitn  <= bitn + 4'd1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == LAST) begin
            state <= RX_HUNT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int DEPTH = 8,   // power of two
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         wr,
  input  logic [W-1:0] din,
  input  logic         rd,
  output logic         empty,
  output logic         full,
  output logic [W-1:0] head
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign head  = empty ? '0 : mem[rp[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr) wp <= wp + 1'b1;
      if (rd) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !flush) mem[wp[AW-1:0]] <= din;
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OVERSAMPLE  = 16,
  parameter int FIFO_DEPTH  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_line,
  input  logic        tick16,
  input  logic        cfg_seven,
  input  logic        cfg_par_en,
  input  logic        cfg_wr,
  input  logic        rd_pop,
  input  logic        sleep,
  output logic [7:0]  head_data,
  output logic        head_par,
  output logic        data_avail,
  output logic        fault_wake
);
  logic              rx_s, rx_prev, sleep_q;
  logic              frame_done, stop_ok;
  logic [SRX_EW-1:0] frame_word, head_word;
  logic              fifo_empty, fifo_full;
  logic              push_ev, fifo_wr, pop_ev, sleep_edge, act_edge;
  logic              err_q;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s)
  );

  srx_deframer #(.OVERSAMPLE(OVERSAMPLE)) u_defr (
    .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .tick(tick16),
    .seven(cfg_seven), .par_en(cfg_par_en), .hold(sleep),
    .frame_done(frame_done), .stop_ok(stop_ok), .frame_word(frame_word)
  );

  // named events
  assign push_ev    = frame_done && stop_ok;
  assign fifo_wr    = push_ev && !fifo_full;
  assign pop_ev     = rd_pop && !fifo_empty;
  assign sleep_edge = sleep != sleep_q;
  assign act_edge   = sleep && sleep_q && (rx_s != rx_prev);

  srx_fifo #(.DEPTH(FIFO_DEPTH), .W(SRX_EW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(sleep), .wr(fifo_wr), .din(frame_word),
    .rd(pop_ev), .empty(fifo_empty), .full(fifo_full), .head(head_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_prev <= 1'b1;
      sleep_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      rx_prev <= rx_s;
      sleep_q <= sleep;
      if (sleep_edge)          err_q <= 1'b0;
      else if (act_edge)       err_q <= 1'b1;
      else if (frame_done)     err_q <= !stop_ok;
      else if (cfg_wr && !sleep) err_q <= 1'b0;
    end
  end

  assign head_data  = head_word[7:0];
  assign head_par   = head_word[8];
  assign data_avail = !fifo_empty;
  assign fault_wake = err_q;
endmodule

// File: rtl/srx_chk.sv
module srx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep,
  input logic       rd_pop,
  input logic       cfg_wr,
  input logic       rx_s,
  input logic       frame_done,
  input logic       stop_ok,
  input logic       push_ev,
  input logic       fifo_full,
  input logic [7:0] head_data,
  input logic       head_par,
  input logic       data_avail,
  input logic       fault_wake
);
  // R10
  sleep_enter_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep) |=> !fault_wake && !data_avail);

  // R10
  sleep_exit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |=> !fault_wake);

  // R6
  empty_head_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_avail |-> (head_data == 8'h00) && !head_par);

  // R6
  avail_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_avail) |-> $past(rd_pop) || $past(sleep));

  // R7
  bad_stop_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !stop_ok |=> fault_wake);

  // R8
  good_stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && stop_ok |=> !fault_wake);

  // R8
  pop_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop && !cfg_wr && !frame_done && !sleep && !$past(sleep) |=> $stable(fault_wake));

  // R11
  wake_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep && $past(sleep) && (rx_s != $past(rx_s)) |=> fault_wake);

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev && fifo_full && !rd_pop && !sleep |=> $stable(head_data) && data_avail);
endmodule

bind serial_rx_core srx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .rd_pop(rd_pop), .cfg_wr(cfg_wr),
  .rx_s(rx_s), .frame_done(frame_done), .stop_ok(stop_ok), .push_ev(push_ev),
  .fifo_full(fifo_full), .head_data(head_data), .head_par(head_par),
  .data_avail(data_avail), .fault_wake(fault_wake)
);

// File: tb/sim_serial_rx_core.sv
module sim_serial_rx_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       tick16 = 1'b0;
  logic       cfg_seven = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       rd_pop = 1'b0;
  logic       sleep = 1'b0;
  logic [7:0] head_data;
  logic       head_par, data_avail, fault_wake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam int BIT_CLKS = 32;  // 16 ticks, one tick every 2 clocks

  always #4 clk = ~clk;  // 125 MHz

  serial_rx_core u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
    .cfg_seven(cfg_seven), .cfg_par_en(cfg_par_en), .cfg_wr(cfg_wr),
    .rd_pop(rd_pop), .sleep(sleep), .head_data(head_data), .head_par(head_par),
    .data_avail(data_avail), .fault_wake(fault_wake)
  );

  initial begin
    forever begin
      @(negedge clk);
      tick16 = ~tick16;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_time(input logic b);
    rx_line = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic seven, input logic pe,
                            input logic p, input logic good);
    bit_time(1'b0);
    for (int i = 0; i < (seven ? 7 : 8); i++) bit_time(d[i]);
    if (pe) bit_time(p);
    if (good) begin
      bit_time(1'b1);
      bit_time(1'b1);
    end else begin
      rx_line = 1'b0;
      repeat (24) @(negedge clk);
      rx_line = 1'b1;
      repeat (2 * BIT_CLKS) @(negedge clk);
    end
  endtask

  task automatic pop_one;
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg_pulse;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 avail", data_avail, 0);
    chk("R1 flag", fault_wake, 0);
    chk("R1 data", head_data, 0);
    chk("R1 par", head_par, 0);

    // R2 R4 R6: full 8-bit sweep with parity enabled
    cfg_seven = 1'b0; cfg_par_en = 1'b1;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] d;
      logic p;
      d = 8'(v);
      p = ^d;
      send_frame(d, 1'b0, 1'b1, p, 1'b1);
      chk("R2 avail", data_avail, 1);
      chk("R2 data", head_data, d);
      chk("R4 par", head_par, p);
      pop_one;
      chk("R6 empty", data_avail, 0);
      chk("R6 zero", head_data, 0);
    end

    // R3: 7-bit, no parity; bit 7 of stimulus never sent
    cfg_seven = 1'b1; cfg_par_en = 1'b0;
    for (int v = 0; v < 128; v += 5) begin
      logic [7:0] d;
      d = 8'(v) | 8'h80;
      send_frame(d, 1'b1, 1'b0, 1'b0, 1'b1);
      chk("R3 data", head_data, d & 8'h7f);
      chk("R4 par off", head_par, 0);
      pop_one;
    end

    // R3 R4: 7-bit with parity 1
    cfg_par_en = 1'b1;
    send_frame(8'h2a, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R3 data par", head_data, 8'h2a);
    chk("R4 par seven", head_par, 1);
    pop_one;

    // R4: 8-bit without parity, all ones
    cfg_seven = 1'b0; cfg_par_en = 1'b0;
    send_frame(8'hff, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R4 data", head_data, 8'hff);
    chk("R4 par zero", head_par, 0);
    pop_one;

    // R9: short low pulse
    rx_line = 1'b0;
    repeat (8) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    chk("R9 avail", data_avail, 0);
    chk("R9 flag", fault_wake, 0);

    // R5: nine frames, eight kept in order
    for (int i = 0; i < 9; i++) send_frame(8'(8'h10 + i), 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) begin
      chk("R5 avail", data_avail, 1);
      chk("R5 order", head_data, 8'(8'h10 + i));
      pop_one;
    end
    chk("R5 dropped", data_avail, 0);

    // R7 R8: fault, pop keeps flag, good frame clears it
    send_frame(8'h5a, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 flag", fault_wake, 1);
    chk("R7 not queued", data_avail, 0);
    pop_one;
    chk("R8 pop keeps", fault_wake, 1);
    send_frame(8'h33, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7 recover data", head_data, 8'h33);
    chk("R8 good clears", fault_wake, 0);
    pop_one;

    // R8: configuration write clears
    send_frame(8'hc3, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 flag again", fault_wake, 1);
    cfg_pulse;
    chk("R8 cfg clears", fault_wake, 0);

    // R10 R11: sleep
    send_frame(8'ha1, 1'b0, 1'b0, 1'b0, 1'b1);
    send_frame(8'hb2, 1'b0, 1'b0, 1'b0, 1'b1);
    send_frame(8'h0f, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5 two queued", head_data, 8'ha1);
    chk("R7 flag pre", fault_wake, 1);
    sleep = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 flush", data_avail, 0);
    chk("R10 data zero", head_data, 0);
    chk("R10 enter clear", fault_wake, 0);
    rx_line = 1'b0;
    repeat (6) @(negedge clk);
    chk("R11 wake", fault_wake, 1);
    rx_line = 1'b1;
    repeat (6) @(negedge clk);
    send_frame(8'h55, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 no rx", data_avail, 0);
    sleep = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 exit clear", fault_wake, 0);
    send_frame(8'h3c, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 resume", head_data, 8'h3c);
    pop_one;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule